// File: doc/BRIEF.md
# Overcurrent Event Counting Hiccup Controller

This block is the digital overcurrent supervisor for one channel of a switching step-down converter. Once per switching period an oscillator tick may start a high-side conduction interval. The block gates that tick into the turn-on pulse and passes the PWM drive requests to the switches. It cuts the high-side on-time as soon as the current-limit comparator trips. Each switching period can raise at most one overcurrent event. A saturating event count is kept, and a run of clean periods clears it.

When a current-limit trip coincides with a low feedback reading, the block slows switching to one period in every four oscillator ticks. This gives the inductor time to discharge. It returns to the full rate after a full period with neither flag set. If the event count saturates while power-good is low and protection is enabled, both switches are forced off. The channel then stays off for three soft-start durations, and a restart pulse is issued to begin a new soft-start. All counting advances on switching events, so it works the same way at the full and the folded rates.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: `hs_drv_o` equals `hs_req_i` while running, except that it is low in any clock where `ilim_i` is high. After an overcurrent event it stays low until the next `hs_on_o` pulse.
- R2: An overcurrent event is the first `ilim_i` assertion in a switching period that was opened by an `hs_on_o` pulse. No event can occur before the first pulse after reset or restart. Each event raises `oc_count_o` by one on the next clock, and the count saturates at 15.
- R3: If an event leaves the count at 15 while `pgood_i` is low and `hiccup_en_i` is high, then on the next clock `hiccup_o` rises and `hiccup_event_o` pulses for one clock. While `hiccup_o` is high, `hs_drv_o`, `ls_drv_o` and `hs_on_o` stay low. With `pgood_i` high or `hiccup_en_i` low, no hiccup is entered.
- R4: At the `hs_on_o` pulse that closes the 15th consecutive event-free period, `oc_count_o` returns to 0. Any event restarts that run.
- R5: `hs_on_o` is `osc_tick_i` gated by running state. While `fold_o` is high, only every 4th tick passes, and the first tick to pass is the 4th one after entry. `fold_o` rises on the clock after an event that occurs with `fb_low_i` high.
- R6: `fold_o` falls at an `hs_on_o` pulse that ends a full period in which neither `ilim_i` nor `fb_low_i` was high, including the pulse clock itself.
- R7: `hiccup_o` stays high for exactly 3 × `ss_ticks_i` clocks, using the value sampled at entry (`ss_ticks_i` ≥ 1). `ss_start_o` pulses for one clock as `hiccup_o` falls.
- R8: The event count, clean run and fold state are held cleared throughout hiccup. After restart, counting begins again only after the first new `hs_on_o` pulse.
- R9: `oc_flag_o` is set by every event and cleared by `oc_clr_i`. A set in the same clock takes priority over a clear.
- R10: `ls_drv_o` follows `ls_req_i` while running.
- R11: After reset all outputs are low and `oc_count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | Full-rate switching period tick |
| ilim_i | input | 1 | High-side current-limit comparator |
| fb_low_i | input | 1 | Feedback-below-threshold comparator |
| pgood_i | input | 1 | Output power-good |
| hiccup_en_i | input | 1 | Hiccup protection enable (normally high) |
| ss_ticks_i | input | SS_W | Soft-start duration in clocks |
| hs_req_i | input | 1 | High-side drive request from PWM |
| ls_req_i | input | 1 | Low-side drive request from PWM |
| oc_clr_i | input | 1 | Clear strobe for the sticky status |
| hs_on_o | output | 1 | Gated turn-on pulse |
| hs_drv_o | output | 1 | High-side switch drive |
| ls_drv_o | output | 1 | Low-side switch drive |
| fold_o | output | 1 | Fold-back active |
| oc_count_o | output | CNT_W | Overcurrent event count |
| oc_flag_o | output | 1 | Sticky overcurrent status |
| hiccup_o | output | 1 | Channel held off in hiccup |
| hiccup_event_o | output | 1 | One-clock pulse on hiccup entry |
| ss_start_o | output | 1 | One-clock soft-start restart pulse |

## Verification
The hardest state to reach is a hiccup entry. Fifteen events have to pile up without any stretch of fifteen clean periods between them, and power-good has to be low at the last one. The clean-run clear is the exact opposite of this. The random phases therefore push current-limit assertions to a high rate with power-good held low, and other phases hold power-good high or protection disabled to show that saturation alone does nothing. A directed sequence places three events and then exactly fourteen and fifteen clean periods. Another steps the fold-back divider tick by tick through one entry and one exit.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    HS_RUN  = 1'b0,
    HS_HOLD = 1'b1
  } hold_state_e;
endpackage

// File: rtl/ocp_fold_gate.sv
module ocp_fold_gate #(
  parameter int FOLD_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic trig_i,
  input  logic tick_i,
  input  logic ilim_i,
  input  logic fb_low_i,
  input  logic oc_evt_i,
  output logic hs_on_o,
  output logic fold_o
);
  localparam int DIV_W = (FOLD_DIV > 1) ? $clog2(FOLD_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FOLD_DIV - 1);

  logic             fold_q, dirty_q;
  logic [DIV_W-1:0] div_q;
  logic             pass, stress, enter, leave;

  assign pass    = !fold_q || (div_q == DIV_LAST);
  assign hs_on_o = tick_i && run_i && pass;
  assign stress  = ilim_i || fb_low_i;
  assign enter   = oc_evt_i && fb_low_i && !fold_q;
  // a full period without stress closes at a pulse with no stress either
  assign leave   = hs_on_o && fold_q && !dirty_q && !stress;
  assign fold_o  = fold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fold_q  <= 1'b0;
      dirty_q <= 1'b0;
      div_q   <= '0;
    end else if (!run_i || trig_i) begin
      fold_q  <= 1'b0;
      dirty_q <= 1'b0;
      div_q   <= '0;
    end else begin
      dirty_q <= hs_on_o ? stress : (dirty_q || stress);
      if (enter) begin
        fold_q <= 1'b1;
        div_q  <= '0;
      end else if (leave) begin
        fold_q <= 1'b0;
        div_q  <= '0;
      end else if (fold_q && tick_i) begin
        div_q  <= (div_q == DIV_LAST) ? '0 : div_q + DIV_W'(1);
      end
    end
  end

  p_fold_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fold_q) |-> $past(oc_evt_i && fb_low_i));

  p_fold_exit_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(fold_q) && $past(run_i) && !$past(trig_i)) |-> $past(!ilim_i && !fb_low_i && tick_i));

  p_no_pulse_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !hs_on_o);
endmodule

// File: rtl/ocp_event_cnt.sv
module ocp_event_cnt #(
  parameter int CNT_W     = 4,
  parameter int CLEAN_RUN = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hs_on_i,
  input  logic             ilim_i,
  input  logic             pgood_i,
  input  logic             en_i,
  output logic             oc_evt_o,
  output logic             kill_o,
  output logic             trig_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TC     = {CNT_W{1'b1}};
  localparam int               CL_W   = $clog2(CLEAN_RUN + 1);
  localparam logic [CL_W-1:0]  CL_END = CL_W'(CLEAN_RUN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic [CL_W-1:0]  clean_q;
  logic             act_q, kill_q;
  logic             oc_evt, clean_close;

  assign oc_evt      = ilim_i && run_i && act_q && !kill_q;
  assign cnt_inc     = (cnt_q == TC) ? TC : cnt_q + CNT_W'(1);
  assign clean_close = hs_on_i && act_q && !kill_q && !oc_evt;
  assign trig_o      = oc_evt && (cnt_inc == TC) && !pgood_i && en_i;
  assign oc_evt_o    = oc_evt;
  assign kill_o      = kill_q;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      clean_q <= '0;
      act_q   <= 1'b0;
      kill_q  <= 1'b0;
    end else if (!run_i || trig_o) begin
      cnt_q   <= '0;
      clean_q <= '0;
      act_q   <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      if (oc_evt) begin
        cnt_q   <= cnt_inc;
        clean_q <= '0;
      end else if (clean_close) begin
        if (clean_q == CL_END) begin
          cnt_q   <= '0;
          clean_q <= '0;
        end else begin
          clean_q <= clean_q + CL_W'(1);
        end
      end
      act_q  <= act_q || hs_on_i;
      kill_q <= hs_on_i ? 1'b0 : (kill_q || oc_evt);
    end
  end

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0));

  p_one_evt_per_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_evt && !hs_on_i) |=> !oc_evt_o);

  p_clean_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_q < CL_W'(CLEAN_RUN));

  p_idle_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0) && !act_q);
endmodule

// File: rtl/ocp_hold_fsm.sv
module ocp_hold_fsm
  import ocp_pkg::*;
#(
  parameter int SS_W      = 16,
  parameter int HOLD_MULT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic [SS_W-1:0] ss_ticks_i,
  output logic            run_o,
  output logic            hiccup_o,
  output logic            hiccup_evt_o,
  output logic            ss_start_o
);
  localparam int LIM_W = SS_W + $clog2(HOLD_MULT + 1);

  hold_state_e      st_q;
  logic [LIM_W-1:0] hold_q, lim_q;
  logic             evt_q, ss_q;

  assign run_o        = (st_q == HS_RUN);
  assign hiccup_o     = (st_q == HS_HOLD);
  assign hiccup_evt_o = evt_q;
  assign ss_start_o   = ss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= HS_RUN;
      hold_q <= '0;
      lim_q  <= '0;
      evt_q  <= 1'b0;
      ss_q   <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      ss_q  <= 1'b0;
      unique case (st_q)
        HS_RUN: if (trig_i) begin
          st_q   <= HS_HOLD;
          hold_q <= '0;
          lim_q  <= LIM_W'(ss_ticks_i) * LIM_W'(HOLD_MULT);
          evt_q  <= 1'b1;
        end
        HS_HOLD: if ((hold_q + LIM_W'(1)) >= lim_q) begin
          st_q <= HS_RUN;
          ss_q <= 1'b1;
        end else begin
          hold_q <= hold_q + LIM_W'(1);
        end
        default: st_q <= HS_RUN;
      endcase
    end
  end

  p_entry_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiccup_evt_o |-> hiccup_o && $past(st_q == HS_RUN) && $past(trig_i));

  p_restart_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_start_o |-> run_o && $past(st_q == HS_HOLD));

  p_hold_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiccup_o |-> hold_q < lim_q || lim_q == '0);
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int CNT_W     = 4,
  parameter int CLEAN_RUN = 15,
  parameter int FOLD_DIV  = 4,
  parameter int SS_W      = 16,
  parameter int HOLD_MULT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             ilim_i,
  input  logic             fb_low_i,
  input  logic             pgood_i,
  input  logic             hiccup_en_i,
  input  logic [SS_W-1:0]  ss_ticks_i,
  input  logic             hs_req_i,
  input  logic             ls_req_i,
  input  logic             oc_clr_i,
  output logic             hs_on_o,
  output logic             hs_drv_o,
  output logic             ls_drv_o,
  output logic             fold_o,
  output logic [CNT_W-1:0] oc_count_o,
  output logic             oc_flag_o,
  output logic             hiccup_o,
  output logic             hiccup_event_o,
  output logic             ss_start_o
);
  logic run, trig, oc_evt, kill, hs_on, flag_q;

  ocp_hold_fsm #(.SS_W(SS_W), .HOLD_MULT(HOLD_MULT)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (trig),
    .ss_ticks_i   (ss_ticks_i),
    .run_o        (run),
    .hiccup_o     (hiccup_o),
    .hiccup_evt_o (hiccup_event_o),
    .ss_start_o   (ss_start_o)
  );

  ocp_fold_gate #(.FOLD_DIV(FOLD_DIV)) u_fold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .trig_i   (trig),
    .tick_i   (osc_tick_i),
    .ilim_i   (ilim_i),
    .fb_low_i (fb_low_i),
    .oc_evt_i (oc_evt),
    .hs_on_o  (hs_on),
    .fold_o   (fold_o)
  );

  ocp_event_cnt #(.CNT_W(CNT_W), .CLEAN_RUN(CLEAN_RUN)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .hs_on_i  (hs_on),
    .ilim_i   (ilim_i),
    .pgood_i  (pgood_i),
    .en_i     (hiccup_en_i),
    .oc_evt_o (oc_evt),
    .kill_o   (kill),
    .trig_o   (trig),
    .cnt_o    (oc_count_o)
  );

  // on-time ends in the same clock the limit trips, and stays cut until the next turn-on
  assign hs_on_o  = hs_on;
  assign hs_drv_o = hs_req_i && run && !kill && !ilim_i;
  assign ls_drv_o = ls_req_i && run;
  assign oc_flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (oc_evt)    flag_q <= 1'b1;
    else if (oc_clr_i)  flag_q <= 1'b0;
  end

  p_drv_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiccup_o |-> !hs_drv_o && !ls_drv_o && !hs_on_o);

  p_cut_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_evt && !hs_on) |=> !hs_drv_o);

  p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_evt |=> oc_flag_o);
endmodule

// File: tb/tb_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module tb_ocp_hiccup_ctrl;
  localparam int SS_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, ilim = 0, fbl = 0, pg = 0, en = 1, hsreq = 0, lsreq = 0, clr = 0;
  logic [SS_W-1:0] ss = 16'd3;
  logic hs_on, hs_drv, ls_drv, fold, flag, hic, hic_ev, ss_st;
  logic [3:0] cnt;

  int n_chk = 0, n_fail = 0, hs_seen = 0;
  int hic_len = 0;

  always #4 clk = ~clk;

  ocp_hiccup_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .ilim_i(ilim), .fb_low_i(fbl),
    .pgood_i(pg), .hiccup_en_i(en), .ss_ticks_i(ss), .hs_req_i(hsreq), .ls_req_i(lsreq),
    .oc_clr_i(clr), .hs_on_o(hs_on), .hs_drv_o(hs_drv), .ls_drv_o(ls_drv), .fold_o(fold),
    .oc_count_o(cnt), .oc_flag_o(flag), .hiccup_o(hic), .hiccup_event_o(hic_ev),
    .ss_start_o(ss_st)
  );

  // behavioural reference of the requirements
  bit m_run, m_act, m_kill, m_fold, m_dirty, m_flag, m_ev, m_ss;
  int m_cnt, m_clean, m_div, m_hold, m_limit, m_lim_seen;

  task automatic m_reset();
    m_run = 1; m_act = 0; m_kill = 0; m_fold = 0; m_dirty = 0; m_flag = 0;
    m_ev = 0; m_ss = 0; m_cnt = 0; m_clean = 0; m_div = 0; m_hold = 0; m_limit = 0;
  endtask

  task automatic m_clear();
    m_cnt = 0; m_clean = 0; m_act = 0; m_kill = 0; m_fold = 0; m_div = 0; m_dirty = 0;
  endtask

  function automatic bit f_hs_on();
    return tick && m_run && (!m_fold || m_div == 3);
  endfunction

  function automatic bit f_oc();
    return ilim && m_run && m_act && !m_kill;
  endfunction

  task automatic m_update();
    bit hs, oc, stress, trig;
    int inc;
    hs = f_hs_on(); oc = f_oc(); stress = ilim || fbl;
    m_ev = 0; m_ss = 0;
    if (oc) m_flag = 1; else if (clr) m_flag = 0;
    if (!m_run) begin
      m_clear();
      if (m_hold + 1 >= m_limit) begin m_run = 1; m_ss = 1; end
      else m_hold++;
    end else begin
      inc  = (m_cnt == 15) ? 15 : m_cnt + 1;
      trig = oc && inc == 15 && !pg && en;
      if (trig) begin
        m_run = 0; m_hold = 0; m_limit = 3 * int'(ss); m_lim_seen = m_limit; m_ev = 1;
        m_clear();
      end else begin
        if (oc && fbl && !m_fold) begin m_fold = 1; m_div = 0; end
        else if (hs && m_fold && !m_dirty && !stress) begin m_fold = 0; m_div = 0; end
        else if (m_fold && tick) m_div = (m_div + 1) % 4;
        m_dirty = hs ? stress : (m_dirty || stress);
        if (oc) begin m_cnt = inc; m_clean = 0; end
        else if (hs && m_act && !m_kill) begin
          if (m_clean == 14) begin m_cnt = 0; m_clean = 0; end
          else m_clean++;
        end
        m_act  = m_act || hs;
        m_kill = hs ? 0 : (m_kill || oc);
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_update();
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_comb();
    chk("R5", "hs_on_o", int'(hs_on), int'(f_hs_on()));
    chk("R1", "hs_drv_o", int'(hs_drv), int'(hsreq && m_run && !m_kill && !ilim));
    chk("R10", "ls_drv_o", int'(ls_drv), int'(lsreq && m_run));
    if (hs_on) hs_seen++;
  endtask

  task automatic cmp_regs();
    chk("R2", "oc_count_o", int'(cnt), m_cnt);
    chk("R6", "fold_o", int'(fold), int'(m_fold));
    chk("R3", "hiccup_o", int'(hic), int'(!m_run));
    chk("R3", "hiccup_event_o", int'(hic_ev), int'(m_ev));
    chk("R7", "ss_start_o", int'(ss_st), int'(m_ss));
    chk("R9", "oc_flag_o", int'(flag), int'(m_flag));
    if (hic) begin
      chk("R8", "count held clear in hiccup", int'(cnt), 0);
      hic_len++;
    end else if (hic_len != 0) begin
      chk("R7", "hiccup length", hic_len, m_lim_seen);
      hic_len = 0;
    end
  endtask

  // inputs are already set at a falling edge
  task automatic cyc();
    #1 cmp_comb();
    @(posedge clk);
    @(negedge clk);
    cmp_regs();
  endtask

  task automatic drive(input bit t, input bit i, input bit f);
    tick = t; ilim = i; fbl = f; cyc();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0; ilim = 0; fbl = 0; clr = 0; hsreq = 0; lsreq = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  task automatic rand_phase(input int n, input int p_tick, input int p_ilim, input int p_fb,
                            input int p_pg, input bit e, input int s);
    en = e; ss = SS_W'(s);
    for (int k = 0; k < n; k++) begin
      tick = pct(p_tick); ilim = pct(p_ilim); fbl = pct(p_fb); pg = pct(p_pg);
      hsreq = pct(60); lsreq = pct(50); clr = pct(5);
      cyc();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int seed_v;
    seed_v = $urandom(32'd5501);
    do_reset();
    // R11: reset state
    #1;
    chk("R11", "reset count", int'(cnt), 0);
    chk("R11", "reset outputs", int'({hs_on, hs_drv, ls_drv, fold, flag, hic, hic_ev, ss_st}), 0);

    // R4 directed: 3 events, then 14 clean periods keep the count, the 15th clears it
    pg = 1; en = 1; hsreq = 1;
    for (int k = 0; k < 3; k++) begin drive(1, 0, 0); drive(0, 1, 0); end
    for (int k = 0; k < 15; k++) begin drive(1, 0, 0); drive(0, 0, 0); end
    chk("R4", "count after 14 clean periods", int'(cnt), 3);
    drive(1, 0, 0);
    chk("R4", "count after 15th clean period", int'(cnt), 0);

    // R5/R6 directed: fold entry, one pulse per 4 ticks, exit after a clean folded period
    do_reset();
    pg = 1; hsreq = 1;
    drive(1, 0, 0);
    drive(0, 1, 1);
    chk("R5", "fold entered", int'(fold), 1);
    hs_seen = 0;
    for (int k = 0; k < 8; k++) drive(1, 0, 0);
    chk("R5", "pulses over 8 folded ticks", hs_seen, 2);
    chk("R6", "fold left", int'(fold), 0);
    hs_seen = 0;
    drive(1, 0, 0);
    chk("R6", "full rate restored", hs_seen, 1);

    // R3/R7/R8: enable low, then random mixes
    do_reset();
    rand_phase(3000, 40, 50, 0, 0, 1, 3);
    rand_phase(2000, 40, 40, 0, 100, 1, 3);
    rand_phase(2000, 40, 40, 0, 0, 0, 2);
    rand_phase(3000, 40, 8, 0, 30, 1, 4);
    rand_phase(3000, 50, 30, 40, 20, 1, 2);
    rand_phase(3000, 50, 10, 15, 0, 1, 5);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule